// File: doc/BRIEF.md
# Host Slave Port with Status Byte

This block is the host-facing side of an 8-bit peripheral controller. An external host uses chip select, read and write strobes and a command/data select line to put bytes into an input buffer, take bytes from an output buffer and read an 8-bit status byte. The local core, running on its own clock, has a simple pulse-driven interface on the other side. It can take the input byte, load the output byte, set the four user status bits and the F0 flag, and program three pin-control bits. The host strobes are brought into the core clock through a synchroniser. Every flag change is applied only after a strobe has ended.

The two buffer-full flags can also be routed to interrupt pins for the host. A DMA request/acknowledge pair is available too: when DMA mode is on, the acknowledge input selects the data buffers in place of the chip select. While the host is reading the status byte, the byte is held steady. Any status update from the core during that read waits and takes effect once the read ends.

Top module: `host_slave_port`

## Requirements
- R1: After reset the status byte is 0x00, flag mode and DMA mode are off, all three pin-control bits are 0, and pin_obf, pin_ibf_n and dma_drq are all low.
- R2: The status byte is {user[3:0], F1, F0, IBF, OBF}, with OBF at bit 0. It is visible on core_status. On host_dout it appears when host_a0=1; when host_a0=0, host_dout shows the output buffer.
- R3: A selected host write stores host_din into the input buffer and sets IBF. IBF stays 0 while the write strobe is low and is set within 4 clock cycles after host_wr_n rises.
- R4: A selected host write sets F1 to the value of host_a0 during that write: 1 for a command, 0 for data.
- R5: A selected host read with host_a0=0 clears OBF after host_rd_n rises. A status read leaves OBF unchanged.
- R6: While a selected status read is in progress, core updates to the status byte (user bits, F0, IBF clear, OBF set) are held back. They all take effect once the read has ended.
- R7: A core_stat_wr pulse copies core_wdata[7:4] into status bits 7:4 and leaves bits 3:0 unchanged.
- R8: A core_ibuf_rd pulse clears IBF. A core_obuf_wr pulse loads core_wdata into the output buffer and sets OBF.
- R9: A core_ctl_wr pulse stores core_wdata[4] as the OBF-pin control and core_wdata[5] as the IBF-pin control. With flag mode off, each pin shows its control bit. With flag mode on, pin_obf shows OBF when its control bit is 1, pin_ibf_n shows the inverse of IBF when its control bit is 1, and each pin is held low when its control bit is 0.
- R10: In DMA mode, a core_ctl_wr with core_wdata[6]=1 raises dma_drq. DMA request is cleared when a host read or write strobe ends while the acknowledge line selects the buffers, and also by a core_dma_en pulse.
- R11: In DMA mode, host_dack_n low selects the data buffers whatever host_cs_n is, and the access is treated as data (host_a0 is ignored). Outside DMA mode, host_dack_n has no effect.
- R12: Host strobes with host_cs_n high, and no DMA acknowledge in effect, change neither the buffers nor the flags.
- R13: A core_f0_wr pulse sets F0 to core_wdata[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host command/data select (1 = command or status) |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data (status byte or output buffer) |
| host_dack_n | input | 1 | DMA acknowledge, active low |
| core_ibuf_rd | input | 1 | Core takes the input byte (clears IBF) |
| core_ibuf_data | output | 8 | Input buffer contents |
| core_obuf_wr | input | 1 | Core loads the output buffer (sets OBF) |
| core_stat_wr | input | 1 | Core writes status bits 7:4 |
| core_f0_wr | input | 1 | Core writes F0 |
| core_ctl_wr | input | 1 | Core writes the pin-control bits |
| core_flag_en | input | 1 | Turns flag mode on |
| core_dma_en | input | 1 | Turns DMA mode on and clears the DMA request |
| core_wdata | input | 8 | Core write data for all core writes |
| core_status | output | 8 | Current status byte |
| pin_obf | output | 1 | Output-buffer-full interrupt pin |
| pin_ibf_n | output | 1 | Input-buffer-empty interrupt pin (inverse of IBF) |
| dma_drq | output | 1 | DMA request pin |

## Verification
The assertions assume a well-behaved host: it never has a read and a write strobe active together, and it holds chip select, acknowledge, A0 and write data steady for the whole time a strobe is low. The stimulus keeps every strobe low for four cycles and leaves five cycles after each rising edge, so the two-flop synchroniser always sees a clean pulse. Core pulses last one cycle, and they are never issued in the same cycle as a host strobe's trailing edge. Because of this, IBF, OBF, F1 and the DMA request only change as the result of a strobe edge or a core pulse, and the status byte is free of host-side changes while it is frozen.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int unsigned DW      = 8;
    localparam int unsigned USR_LO  = 4;
    localparam int unsigned USR_W   = DW - USR_LO;

    // status bit positions (host software decodes these)
    localparam int unsigned B_OBF   = 0;
    localparam int unsigned B_IBF   = 1;
    localparam int unsigned B_F0    = 2;
    localparam int unsigned B_F1    = 3;

    // core_wdata bit positions for a pin-control write
    localparam int unsigned CTL_OBF = 4;
    localparam int unsigned CTL_IBF = 5;
    localparam int unsigned CTL_DRQ = 6;

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        byte_t              ibuf;
        byte_t              obuf;
        logic [USR_W-1:0]   usr;
        logic               f1;
        logic               f0;
        logic               ibf;
        logic               obf;
        logic               wr_sel;
        logic               wr_a0;
        logic               wr_dack;
        byte_t              wr_data;
        logic               rd_sel;
        logic               rd_stat;
        logic               rd_dack;
        logic               flag_en;
        logic               dma_en;
        logic               ctl_obf;
        logic               ctl_ibf;
        logic               ctl_drq;
        logic               drq;
        logic               pend_usr_v;
        logic [USR_W-1:0]   pend_usr;
        logic               pend_f0_v;
        logic               pend_f0;
        logic               pend_ibf_clr;
        logic               pend_obf_set;
    } regs_t;

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
    parameter int unsigned N      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_n,
    output logic [N-1:0] level_n,
    output logic [N-1:0] trail
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_ch
            // sh[STAGES-1:0] is the synchroniser chain, sh[STAGES] the previous value
            logic [STAGES:0] sh_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= {sh_q[STAGES-1:0], async_n[g]};
            end

            assign level_n[g] = sh_q[STAGES-1];
            assign trail[g]   = sh_q[STAGES-1] & ~sh_q[STAGES];
        end
    endgenerate

endmodule

// File: rtl/hsp_pin_mux.sv
module hsp_pin_mux (
    input  logic flag_en,
    input  logic dma_en,
    input  logic ctl_obf,
    input  logic ctl_ibf,
    input  logic ctl_drq,
    input  logic obf,
    input  logic ibf,
    input  logic drq,
    output logic pin_obf,
    output logic pin_ibf_n,
    output logic pin_drq
);

    always_comb begin
        pin_obf   = flag_en ? (ctl_obf & obf)  : ctl_obf;
        pin_ibf_n = flag_en ? (ctl_ibf & ~ibf) : ctl_ibf;
        pin_drq   = dma_en  ? drq              : ctl_drq;
    end

endmodule

// File: rtl/host_slave_port.sv
module host_slave_port
    import hsp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cs_n,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    input  logic          host_a0,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    input  logic          host_dack_n,
    input  logic          core_ibuf_rd,
    output logic [DW-1:0] core_ibuf_data,
    input  logic          core_obuf_wr,
    input  logic          core_stat_wr,
    input  logic          core_f0_wr,
    input  logic          core_ctl_wr,
    input  logic          core_flag_en,
    input  logic          core_dma_en,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] core_status,
    output logic          pin_obf,
    output logic          pin_ibf_n,
    output logic          dma_drq
);

    regs_t q, d;

    logic [1:0] strb_n, lvl_n, trail;
    logic       wr_act, rd_act, wr_trail, rd_trail;
    logic       dack_sel, sel_now, frozen, dma_mode;
    byte_t      status;

    assign strb_n = {host_rd_n, host_wr_n};

    hsp_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (strb_n),
        .level_n (lvl_n),
        .trail   (trail)
    );

    assign wr_act   = ~lvl_n[0];
    assign rd_act   = ~lvl_n[1];
    assign wr_trail = trail[0];
    assign rd_trail = trail[1];

    assign dma_mode = q.dma_en;
    assign dack_sel = q.dma_en & ~host_dack_n;
    assign sel_now  = ~host_cs_n | dack_sel;
    assign frozen   = q.rd_stat;
    assign status   = {q.usr, q.f1, q.f0, q.ibf, q.obf};

    always_comb begin
        d = q;

        // capture the access attributes while a strobe is held low
        if (wr_act) begin
            d.wr_sel  = sel_now;
            d.wr_a0   = host_a0 & ~dack_sel;
            d.wr_dack = dack_sel;
            d.wr_data = host_din;
        end
        if (rd_act) begin
            d.rd_sel  = sel_now;
            d.rd_stat = sel_now & host_a0 & ~dack_sel;
            d.rd_dack = dack_sel;
        end

        // commit on the trailing edge
        if (wr_trail) begin
            if (q.wr_sel) begin
                d.ibuf = q.wr_data;
                d.ibf  = 1'b1;
                d.f1   = q.wr_a0;
                if (q.wr_dack) d.drq = 1'b0;
            end
            d.wr_sel  = 1'b0;
            d.wr_a0   = 1'b0;
            d.wr_dack = 1'b0;
        end
        if (rd_trail) begin
            if (q.rd_sel && !q.rd_stat) begin
                d.obf = 1'b0;
                if (q.rd_dack) d.drq = 1'b0;
            end
            d.rd_sel  = 1'b0;
            d.rd_stat = 1'b0;
            d.rd_dack = 1'b0;
        end

        // core side, not part of the status byte
        if (core_obuf_wr) d.obuf = core_wdata;
        if (core_ctl_wr) begin
            d.ctl_obf = core_wdata[CTL_OBF];
            d.ctl_ibf = core_wdata[CTL_IBF];
            d.ctl_drq = core_wdata[CTL_DRQ];
            if (q.dma_en && core_wdata[CTL_DRQ]) d.drq = 1'b1;
        end
        if (core_flag_en) d.flag_en = 1'b1;
        if (core_dma_en) begin
            d.dma_en = 1'b1;
            d.drq    = 1'b0;
        end

        // core side, status byte: deferred while the host reads it
        if (frozen) begin
            if (core_stat_wr) begin
                d.pend_usr_v = 1'b1;
                d.pend_usr   = core_wdata[DW-1:USR_LO];
            end
            if (core_f0_wr) begin
                d.pend_f0_v = 1'b1;
                d.pend_f0   = core_wdata[0];
            end
            if (core_ibuf_rd) d.pend_ibf_clr = 1'b1;
            if (core_obuf_wr) d.pend_obf_set = 1'b1;
        end else begin
            if (q.pend_usr_v)   d.usr = q.pend_usr;
            if (q.pend_f0_v)    d.f0  = q.pend_f0;
            if (q.pend_ibf_clr) d.ibf = 1'b0;
            if (q.pend_obf_set) d.obf = 1'b1;
            d.pend_usr_v   = 1'b0;
            d.pend_f0_v    = 1'b0;
            d.pend_ibf_clr = 1'b0;
            d.pend_obf_set = 1'b0;
            if (core_stat_wr) d.usr = core_wdata[DW-1:USR_LO];
            if (core_f0_wr)   d.f0  = core_wdata[0];
            if (core_ibuf_rd) d.ibf = 1'b0;
            if (core_obuf_wr) d.obf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        host_dout = (host_a0 && !dack_sel) ? status : q.obuf;
    end

    assign core_ibuf_data = q.ibuf;
    assign core_status    = status;

    hsp_pin_mux u_pins (
        .flag_en   (q.flag_en),
        .dma_en    (dma_mode),
        .ctl_obf   (q.ctl_obf),
        .ctl_ibf   (q.ctl_ibf),
        .ctl_drq   (q.ctl_drq),
        .obf       (q.obf),
        .ibf       (q.ibf),
        .drq       (q.drq),
        .pin_obf   (pin_obf),
        .pin_ibf_n (pin_ibf_n),
        .pin_drq   (dma_drq)
    );

endmodule

// File: rtl/hsp_checks.sv
module hsp_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic       wr_trail,
    input logic       rd_trail,
    input logic       frozen,
    input logic       dma_mode,
    input logic       core_dma_en,
    input logic       dma_drq
);

    // R3: IBF is only ever set by the end of a host write
    a_r3_ibf_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(wr_trail));

    // R4: F1 only moves at the end of a host write
    a_r4_f1_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[3]) |-> $past(wr_trail));

    // R5: OBF is only cleared by the end of a host read
    a_r5_obf_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> $past(rd_trail));

    // R6: the status byte is held while the host reads it
    a_r6_frozen_status: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(status));

    // R10: in DMA mode the request drops only on an acknowledged strobe end or a re-enable
    a_r10_drq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dma_drq) && dma_mode && $past(dma_mode)) |->
            $past(wr_trail || rd_trail || core_dma_en));

endmodule

bind host_slave_port hsp_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status      (status),
    .wr_trail    (wr_trail),
    .rd_trail    (rd_trail),
    .frozen      (frozen),
    .dma_mode    (dma_mode),
    .core_dma_en (core_dma_en),
    .dma_drq     (dma_drq)
);

// File: tb/host_slave_port_test.sv
module host_slave_port_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_cs_n, host_rd_n, host_wr_n, host_a0, host_dack_n;
    logic [7:0] host_din, host_dout;
    logic       core_ibuf_rd, core_obuf_wr, core_stat_wr, core_f0_wr;
    logic       core_ctl_wr, core_flag_en, core_dma_en;
    logic [7:0] core_wdata, core_ibuf_data, core_status;
    logic       pin_obf, pin_ibf_n, dma_drq;

    always #2 clk = ~clk;

    host_slave_port uut (
        .clk(clk), .rst_n(rst_n),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_a0(host_a0), .host_din(host_din), .host_dout(host_dout),
        .host_dack_n(host_dack_n),
        .core_ibuf_rd(core_ibuf_rd), .core_ibuf_data(core_ibuf_data),
        .core_obuf_wr(core_obuf_wr), .core_stat_wr(core_stat_wr),
        .core_f0_wr(core_f0_wr), .core_ctl_wr(core_ctl_wr),
        .core_flag_en(core_flag_en), .core_dma_en(core_dma_en),
        .core_wdata(core_wdata), .core_status(core_status),
        .pin_obf(pin_obf), .pin_ibf_n(pin_ibf_n), .dma_drq(dma_drq)
    );

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    item_t q_exp[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    // monitor: pops one expectation per falling edge and compares
    initial begin
        forever begin
            item_t      it;
            logic [7:0] act;
            @(negedge clk);
            if (q_exp.size() > 0) begin
                it = q_exp.pop_front();
                case (it.sel)
                    0:       act = core_status;
                    1:       act = host_dout;
                    2:       act = {7'd0, pin_obf};
                    3:       act = {7'd0, pin_ibf_n};
                    4:       act = {7'd0, dma_drq};
                    5:       act = core_ibuf_data;
                    default: act = 'x;
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_val(string req, int sel, logic [7:0] exp);
        q_exp.push_back('{req, sel, exp});
        wait (q_exp.size() == 0);
        tick(1);
    endtask

    // which: 0 ibuf_rd, 1 obuf_wr, 2 stat_wr, 3 f0_wr, 4 ctl_wr, 5 flag_en, 6 dma_en
    task automatic core_pulse(int which, logic [7:0] v);
        core_wdata = v;
        case (which)
            0: core_ibuf_rd = 1'b1;
            1: core_obuf_wr = 1'b1;
            2: core_stat_wr = 1'b1;
            3: core_f0_wr   = 1'b1;
            4: core_ctl_wr  = 1'b1;
            5: core_flag_en = 1'b1;
            default: core_dma_en = 1'b1;
        endcase
        tick(1);
        {core_ibuf_rd, core_obuf_wr, core_stat_wr, core_f0_wr,
         core_ctl_wr, core_flag_en, core_dma_en} = '0;
        tick(1);
    endtask

    task automatic hbegin(bit is_wr, bit cs_n, bit dack_n, bit a0, logic [7:0] v);
        host_cs_n   = cs_n;
        host_dack_n = dack_n;
        host_a0     = a0;
        host_din    = v;
        if (is_wr) host_wr_n = 1'b0;
        else       host_rd_n = 1'b0;
        tick(4);
    endtask

    task automatic hend();
        host_wr_n = 1'b1;
        host_rd_n = 1'b1;
        tick(5);
        host_cs_n   = 1'b1;
        host_dack_n = 1'b1;
        host_a0     = 1'b0;
        tick(1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
        host_a0 = 1'b0; host_dack_n = 1'b1; host_din = '0;
        {core_ibuf_rd, core_obuf_wr, core_stat_wr, core_f0_wr,
         core_ctl_wr, core_flag_en, core_dma_en} = '0;
        core_wdata = '0;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        expect_val("R1 status", 0, 8'h00);
        expect_val("R1 pin_obf", 2, 8'h00);
        expect_val("R1 pin_ibf_n", 3, 8'h00);
        expect_val("R1 drq", 4, 8'h00);

        // R3/R4 data write
        hbegin(1, 0, 1, 0, 8'h5A);
        expect_val("R3 IBF before trailing edge", 0, 8'h00);
        hend();
        expect_val("R3 R4 status after data write", 0, 8'h02);
        expect_val("R3 input buffer", 5, 8'h5A);
        core_pulse(0, 8'h00);
        expect_val("R8 IBF cleared by core", 0, 8'h00);

        // R4 command write
        hbegin(1, 0, 1, 1, 8'hC3);
        hend();
        expect_val("R4 F1 on command", 0, 8'h0A);
        core_pulse(0, 8'h00);
        expect_val("R8 IBF clear keeps F1", 0, 8'h08);

        // R7 / R13
        core_pulse(2, 8'h9F);
        expect_val("R7 upper nibble only", 0, 8'h98);
        core_pulse(3, 8'h01);
        expect_val("R13 F0 set", 0, 8'h9C);

        // R8 / R2 / R5
        core_pulse(1, 8'h3C);
        expect_val("R8 OBF set", 0, 8'h9D);
        hbegin(0, 0, 1, 1, 8'h00);
        expect_val("R2 status on host bus", 1, 8'h9D);
        hend();
        expect_val("R5 status read keeps OBF", 0, 8'h9D);
        hbegin(0, 0, 1, 0, 8'h00);
        expect_val("R2 output buffer on host bus", 1, 8'h3C);
        hend();
        expect_val("R5 OBF cleared by data read", 0, 8'h9C);

        // R12 / R11 ignored accesses
        hbegin(1, 1, 1, 0, 8'h77);
        hend();
        expect_val("R12 deselected write flags", 0, 8'h9C);
        expect_val("R12 deselected write buffer", 5, 8'hC3);
        hbegin(1, 1, 0, 0, 8'h66);
        hend();
        expect_val("R11 acknowledge ignored outside DMA mode", 0, 8'h9C);
        expect_val("R11 buffer untouched outside DMA mode", 5, 8'hC3);
        core_pulse(1, 8'h11);
        hbegin(0, 1, 1, 0, 8'h00);
        hend();
        expect_val("R12 deselected read keeps OBF", 0, 8'h9D);
        hbegin(0, 0, 1, 0, 8'h00);
        hend();
        expect_val("R5 clear OBF", 0, 8'h9C);

        // R6 freeze during status read
        hbegin(0, 0, 1, 1, 8'h00);
        core_pulse(2, 8'h50);
        core_pulse(1, 8'h22);
        expect_val("R6 status held during read", 0, 8'h9C);
        expect_val("R6 host sees held status", 1, 8'h9C);
        hend();
        expect_val("R6 deferred updates applied", 0, 8'h5D);
        hbegin(0, 0, 1, 0, 8'h00);
        expect_val("R8 output buffer loaded during freeze", 1, 8'h22);
        hend();
        expect_val("R5 clear after freeze", 0, 8'h5C);

        // R9 pin controls and flag mode
        core_pulse(4, 8'h30);
        expect_val("R9 pin_obf shows control outside flag mode", 2, 8'h01);
        expect_val("R9 pin_ibf_n shows control outside flag mode", 3, 8'h01);
        core_pulse(5, 8'h00);
        expect_val("R9 pin_obf follows OBF=0", 2, 8'h00);
        expect_val("R9 pin_ibf_n inverse of IBF=0", 3, 8'h01);
        core_pulse(1, 8'h44);
        expect_val("R9 pin_obf follows OBF=1", 2, 8'h01);
        hbegin(1, 0, 1, 0, 8'hAB);
        hend();
        expect_val("R9 pin_ibf_n inverse of IBF=1", 3, 8'h00);
        expect_val("R4 status after flag-mode write", 0, 8'h57);
        core_pulse(4, 8'h00);
        expect_val("R9 pin_obf held low", 2, 8'h00);
        expect_val("R9 pin_ibf_n held low", 3, 8'h00);
        core_pulse(0, 8'h00);
        hbegin(0, 0, 1, 0, 8'h00);
        hend();
        expect_val("R8 R5 cleanup", 0, 8'h54);

        // R10 / R11 DMA
        core_pulse(6, 8'h00);
        expect_val("R10 request low after enable", 4, 8'h00);
        core_pulse(4, 8'h40);
        expect_val("R10 request raised", 4, 8'h01);
        hbegin(1, 1, 0, 1, 8'hE1);
        hend();
        expect_val("R11 acknowledged write is data", 0, 8'h56);
        expect_val("R11 acknowledged write buffer", 5, 8'hE1);
        expect_val("R10 request cleared by write", 4, 8'h00);
        core_pulse(4, 8'h40);
        core_pulse(1, 8'h99);
        expect_val("R10 request raised again", 4, 8'h01);
        hbegin(0, 1, 0, 1, 8'h00);
        expect_val("R11 acknowledged read returns buffer", 1, 8'h99);
        hend();
        expect_val("R11 acknowledged read clears OBF", 0, 8'h56);
        expect_val("R10 request cleared by read", 4, 8'h00);
        core_pulse(4, 8'h40);
        core_pulse(6, 8'h00);
        expect_val("R10 request cleared by re-enable", 4, 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule